// File: doc/BRIEF.md
# Sector Buffer Program Engine

This block is the device side of a byte-wide flash array's sector rewrite path, built from synchronous logic. A host issues byte loads. Each load carries a 16-bit address and an 8-bit data byte. The loads collect in a 128-entry sector buffer. When the host stops loading, a gap timer closes the load window. A self-timed cycle then erases the addressed sector and copies the buffered bytes into an array held inside the block. While that cycle runs, the busy flag is high and every read returns a status byte instead of array contents. The host polls that byte to see when the cycle has finished.

Timing is counted in clock cycles. The gap timeout is set by `LOAD_TIMEOUT` (default 20). The length of the busy cycle is set by `PROG_CYCLES` (default 400), which must exceed twice the sector size. To keep the model small, the internal array holds `2**ARR_SECT_W` sectors (default 8). The address decode is unchanged, but sectors alias onto that store.

A state machine controls the block. It has five states:
- IDLE: waits for a first load. A load moves it to LOAD.
- LOAD: collects bytes. It moves to ERASE when the gap timeout expires.
- ERASE: writes all-ones to each byte of the sector, one byte per cycle. After 128 cycles it moves to WRITE.
- WRITE: copies every buffered byte that was loaded. After 128 cycles it moves to SETTLE.
- SETTLE: waits out the rest of the cycle. When the count reaches `PROG_CYCLES` it returns to IDLE.

Top module: `sbpe_top`

## Requirements
- R1: The address splits into a sector number (bits 15..7) and a byte offset (bits 6..0). The array keeps `2**ARR_SECT_W` sectors, indexed by the low `ARR_SECT_W` bits of the sector number, so sector s+8 reads the same storage as sector s at default settings.
- R2: Bytes may be loaded in any order. A later load to the same offset within one window replaces the earlier byte.
- R3: A load is accepted on a clock edge where `wr_en` is 1 and `rd_en` is 0, while the engine is not busy. If an edge carries no accepted load and is the `LOAD_TIMEOUT`-th edge after the last accepted load, busy is high from the next cycle on. A load accepted on that edge, or earlier, restarts the gap count instead.
- R4: Busy stays high for exactly `PROG_CYCLES` clock cycles, then falls by itself.
- R5: After the cycle, each loaded offset of the sector holds its last loaded byte and each unloaded offset reads 8'hFF. All other sectors keep their contents.
- R6: A read sampled while busy returns the last accepted load byte with bit 7 inverted, and bits 5..0 unchanged, whatever the read address.
- R7: In a status read, bit 6 is 0 for the first read after busy rises. Bit 6 then alternates on every further status read until busy falls.
- R8: A write strobe on an edge where `rd_en` is 1 is ignored.
- R9: Within a window, a load whose sector number differs from the first load's sector is ignored. It does not restart the gap count.
- R10: Write strobes while busy are ignored. They change no byte and open no new window.
- R11: After reset, busy and `rdata` are 0. A read sampled on an edge shows in `rdata` from the next cycle. `rdata` holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte load strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe |
| addr | input | 16 | Sector number and byte offset |
| wdata | input | 8 | Byte to load |
| rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | High during the erase and program cycle |

## Verification
Some behaviours are checked by assertions on every cycle:
- Busy can only rise from the LOAD state.
- The captured sector number stays fixed outside IDLE.
- The set of loaded offsets never changes while busy, or on an edge where both strobes are high.
- The source byte for status reads stays fixed during the cycle.
- The array is written only while busy.
- Back-to-back status reads flip bit 6.

Other behaviours can only be shown by the bench's scenarios:
- The exact edge at which the gap timeout fires, and the case where a load on the last allowed edge extends the window.
- The exact length of the busy period.
- The final array contents, including all-ones in unloaded bytes, bytes replaced by later loads, the effect of ignored loads, and sector aliasing.

// File: rtl/sbpe_pkg.sv
package sbpe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ERASE,
        ST_WRITE,
        ST_SETTLE
    } sbpe_state_t;
endpackage

// File: rtl/sbpe_timer.sv
module sbpe_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Free-running cycle counter with synchronous clear.
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sbpe_sector_buf.sv
module sbpe_sector_buf #(
    parameter int OFS_W = 7,
    parameter int DW    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_all,
    input  logic                 we,
    input  logic [OFS_W-1:0]     wofs,
    input  logic [DW-1:0]        wdata,
    input  logic [OFS_W-1:0]     rofs,
    output logic [DW-1:0]        rdata,
    output logic                 rvalid,
    input  logic [OFS_W-1:0]     lofs,
    output logic [DW-1:0]        ldata,
    output logic [(1<<OFS_W)-1:0] valid_o
);
    localparam int NB = 1 << OFS_W;

    logic [DW-1:0] mem [NB];
    logic [NB-1:0] valid_q;

    // Loaded-offset mask: a clear and a write on the same edge leave only the new offset.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (clr_all) valid_q <= '0;
            if (we)      valid_q[wofs] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[wofs] <= wdata;
    end

    assign rdata   = mem[rofs];
    assign rvalid  = valid_q[rofs];
    assign ldata   = mem[lofs];
    assign valid_o = valid_q;
endmodule

// File: rtl/sbpe_array.sv
module sbpe_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [1 << AW];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sbpe_top.sv
module sbpe_top
    import sbpe_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int OFS_W        = 7,
    parameter int ARR_SECT_W   = 3,
    parameter int LOAD_TIMEOUT = 20,
    parameter int PROG_CYCLES  = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);
    localparam int SECT_W     = ADDR_W - OFS_W;
    localparam int SECT_BYTES = 1 << OFS_W;
    localparam int ARR_AW     = ARR_SECT_W + OFS_W;
    localparam int CNT_W      = $clog2(PROG_CYCLES + LOAD_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(LOAD_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(SECT_BYTES - 1);
    localparam logic [CNT_W-1:0] WRITE_LAST = CNT_W'(2 * SECT_BYTES - 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [DATA_W-1:0] STAT_MSB  = DATA_W'(1) << (DATA_W - 1);

    sbpe_state_t         state_q, state_d;
    logic [SECT_W-1:0]   sect_q;
    logic [OFS_W-1:0]    last_ofs_q;
    logic                tgl_q;
    logic [CNT_W-1:0]    cnt;
    logic                cnt_clr;
    logic                wr_acc;
    logic                win_close;
    logic [DATA_W-1:0]   buf_rdata, buf_ldata, arr_rdata, arr_wdata;
    logic                buf_rvalid;
    logic [SECT_BYTES-1:0] buf_valid;
    logic                arr_we;
    logic [ARR_AW-1:0]   arr_waddr;
    logic [DATA_W-1:0]   status;

    wire [SECT_W-1:0] in_sect = addr[ADDR_W-1:OFS_W];
    wire [OFS_W-1:0]  in_ofs  = addr[OFS_W-1:0];

    assign busy   = (state_q == ST_ERASE) || (state_q == ST_WRITE) || (state_q == ST_SETTLE);
    assign wr_acc = wr_en && !rd_en &&
                    ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && (in_sect == sect_q)));
    assign win_close = (state_q == ST_LOAD) && (state_d == ST_ERASE);
    assign cnt_clr   = (state_q == ST_IDLE) || wr_acc || win_close;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_acc)                state_d = ST_LOAD;
            ST_LOAD:   if (!wr_acc && cnt == GAP_LAST) state_d = ST_ERASE;
            ST_ERASE:  if (cnt == ERASE_LAST)     state_d = ST_WRITE;
            ST_WRITE:  if (cnt == WRITE_LAST)     state_d = ST_SETTLE;
            ST_SETTLE: if (cnt == PROG_LAST)      state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // State register and window capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            sect_q     <= '0;
            last_ofs_q <= '0;
        end else begin
            state_q <= state_d;
            if (wr_acc && state_q == ST_IDLE) sect_q <= in_sect;
            if (wr_acc) last_ofs_q <= in_ofs;
        end
    end

    sbpe_timer #(.W(CNT_W)) u_tmr (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .cnt (cnt)
    );

    sbpe_sector_buf #(.OFS_W(OFS_W), .DW(DATA_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr_all (wr_acc && state_q == ST_IDLE),
        .we      (wr_acc),
        .wofs    (in_ofs),
        .wdata   (wdata),
        .rofs    (cnt[OFS_W-1:0]),
        .rdata   (buf_rdata),
        .rvalid  (buf_rvalid),
        .lofs    (last_ofs_q),
        .ldata   (buf_ldata),
        .valid_o (buf_valid)
    );

    // Erase phase writes all-ones; write phase copies only loaded offsets.
    assign arr_we    = (state_q == ST_ERASE) || ((state_q == ST_WRITE) && buf_rvalid);
    assign arr_waddr = {sect_q[ARR_SECT_W-1:0], cnt[OFS_W-1:0]};
    assign arr_wdata = (state_q == ST_ERASE) ? '1 : buf_rdata;

    sbpe_array #(.AW(ARR_AW), .DW(DATA_W)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (addr[ARR_AW-1:0]),
        .rdata (arr_rdata)
    );

    // Status byte: top bit inverted, next bit replaced by the toggle.
    assign status = buf_ldata ^ (STAT_MSB |
                    ((DATA_W'(buf_ldata[DATA_W-2] ^ tgl_q)) << (DATA_W - 2)));

    // Output process
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            tgl_q <= 1'b0;
        end else begin
            if (win_close) tgl_q <= 1'b0;
            if (rd_en) begin
                if (busy) begin
                    rdata <= status;
                    tgl_q <= ~tgl_q;
                end else begin
                    rdata <= arr_rdata;
                end
            end
        end
    end

    AST_BUSY_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(state_q == ST_LOAD)); // R3
    AST_SECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(sect_q)); // R9
    AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(buf_valid)); // R10
    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> $stable(buf_valid)); // R8
    AST_ARR_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy); // R5
    AST_STATUS_SRC: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(last_ofs_q)); // R6
    AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && $past(rd_en && busy)) |=>
        (rdata[DATA_W-2] != $past(rdata[DATA_W-2]))); // R7
endmodule

// File: tb/sim_sbpe_top.sv
module sim_sbpe_top;
    localparam int T = 20;
    localparam int P = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sbpe_top #(.LOAD_TIMEOUT(T), .PROG_CYCLES(P)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic load(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_with_read(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; rd_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 busy after reset", busy, 0);
        check("R11 rdata after reset", rdata, 0);
    endtask

    task automatic t_sector3();
        logic [7:0] v;
        int rise_c;
        int fall_c;
        load(16'h0185, 8'h11);
        load(16'h0180, 8'h22);
        load(16'h0185, 8'h33);
        load_with_read(16'h0181, 8'h55);
        load(16'h01FF, 8'hC4);
        load(16'h0202, 8'h66);
        repeat (T - 2) @(negedge clk);
        check("R3 R9 busy still low one edge before timeout", busy, 0);
        @(negedge clk);
        check("R3 busy high at timeout edge", busy, 1);
        rise_c = cyc;
        rd(16'h0000, v);
        check("R6 R7 first status read", v, 8'h04);
        rd(16'h1234, v);
        check("R7 second status read toggles", v, 8'h44);
        rd(16'h0185, v);
        check("R7 third status read toggles back", v, 8'h04);
        load(16'h0189, 8'h99);
        while (busy && (cyc - rise_c) < 2000) @(negedge clk);
        fall_c = cyc;
        check("R4 busy length", fall_c - rise_c, P);
        repeat (T + 5) @(negedge clk);
        check("R10 no window opened by busy write", busy, 0);
        rd(16'h0185, v); check("R2 overwrite kept last byte", v, 8'h33);
        rd(16'h0180, v); check("R5 loaded byte offset 0", v, 8'h22);
        rd(16'h01FF, v); check("R5 loaded byte offset 127", v, 8'hC4);
        rd(16'h0181, v); check("R8 write with read ignored", v, 8'hFF);
        rd(16'h0189, v); check("R10 busy write ignored", v, 8'hFF);
        rd(16'h0182, v); check("R9 foreign-sector load ignored", v, 8'hFF);
        rd(16'h01C0, v); check("R5 unloaded byte all ones", v, 8'hFF);
        rd(16'h0585, v); check("R1 aliased sector 11 reads sector 3", v, 8'h33);
        rd(16'h0185, v);
        @(negedge clk);
        check("R11 rdata holds without read", rdata, 8'h33);
    endtask

    task automatic t_window_extend();
        logic [7:0] v;
        load(16'h0300, 8'h10);
        repeat (T - 1) @(negedge clk);
        load(16'h0301, 8'h20);
        check("R3 load on last allowed edge keeps window", busy, 0);
        repeat (T - 1) @(negedge clk);
        check("R3 extended window still open", busy, 0);
        @(negedge clk);
        check("R3 extended window closes", busy, 1);
        rd(16'h0000, v);
        check("R6 R7 status for byte 20", v, 8'hA0);
        wait_idle();
        check("R4 cycle finished", busy, 0);
        rd(16'h0300, v); check("R2 offset 0 in sector 6", v, 8'h10);
        rd(16'h0301, v); check("R2 offset 1 in sector 6", v, 8'h20);
        rd(16'h0302, v); check("R5 unloaded in sector 6", v, 8'hFF);
        rd(16'h0185, v); check("R5 sector 3 unchanged", v, 8'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sector3();
        t_window_extend();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule